// File: doc/BRIEF.md
# Field-Timed Parameter Commit Controller

This block sits between a serial register decoder and the imaging core of a video sensor. A host may write sensor control parameters at any moment. Each write lands in a shadow register. The shadow value reaches the working register only at a chosen point in the field timing, so a half-finished exposure or gain change never shows up in the middle of a frame. There are seven parameter categories: fine exposure, coarse exposure, clock division, gain, pan, tilt and video timing. Each category has a pending bit, and the pending bits together form a status word.

The video timing generator supplies single-cycle event strobes and a field parity level. The controller compares these with the pending bits to decide which categories load in each cycle. Exposure values are limited when they load. Coarse exposure is limited by the current field length. Fine exposure is limited by the current line length less an offset that depends on the mode. Gain and clock division can instead be set to load straight from the write. The gain update is held back while the host is in the middle of an auto-increment burst.

A pan update has a separate readout configuration: sub-sample, shuffle and mirror bits. This configuration only marks pan as pending when its value actually changes. The configuration reaches the output together with the pan offset. `rst_n` is asynchronous and active low. It is expected to be released in step with `clk`.

Top module: `shadow_commit_ctrl`

## Requirements
- R1: After reset every working output and every bit of `pend_status` is zero.
- R2: A write with `wr_en`=1 and category code `wr_cat` sets pending bit `pend_status[wr_cat]` and leaves the working output unchanged. The codes are 0 fine exposure, 1 coarse exposure, 2 clock division, 3 gain, 4 pan, 5 tilt and 6 video timing. A pending bit clears on the edge where its working register loads.
- R3: A pending coarse exposure loads on a clock where `ev_dark_first`=1 and `field_odd`=1, and it is never loaded when `field_odd`=0. The loaded value is min(shadow, `field_len`-1).
- R4: A pending tilt loads on a clock where `ev_vis_first`=1 and `field_odd`=1, and on no other event.
- R5: A pending pan loads on a clock where `ev_eof_line`=1 and `field_odd`=1. A pending gain loads under the same condition, subject to R8.
- R6: Fine exposure loads at the odd-field end-of-frame event when video timing is not pending. When video timing is pending, it waits and loads at `ev_odd_to_even`.
- R7: Clock division and video timing load at `ev_odd_to_even`.
- R8: If `burst_active`=1 at the gain load point, gain is not loaded and stays pending until a later end-of-frame event.
- R9: With `imm_gain`=1 (or `imm_clkdiv`=1), a gain (or clock division) write reaches the working output on the write edge and leaves that category not pending.
- R10: Loaded fine exposure is min(shadow, `line_len`-offset). The offset is 51 for `mode_sel` 0 and 3, 86 for 1, and 23 for 2, with a floor of 0.
- R11: A pan offset write always sets pan pending. A `cfg_wr` write sets pan pending only if `cfg_val` differs from the stored configuration shadow. `work_pan_cfg` loads together with pan.
- R12: A write in the same cycle as that category's load event loads the previous shadow value. The new value stays pending for the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Shadow write strobe |
| wr_cat | input | 3 | Category code of the write |
| wr_data | input | DW | Write data |
| burst_active | input | 1 | Host auto-increment burst in progress |
| imm_gain | input | 1 | Gain loads directly on write |
| imm_clkdiv | input | 1 | Clock division loads directly on write |
| cfg_wr | input | 1 | Readout configuration write strobe |
| cfg_val | input | 3 | Sub-sample, shuffle, mirror bits |
| field_odd | input | 1 | Current field is odd |
| ev_dark_first | input | 1 | Active-video start of first dark line |
| ev_vis_first | input | 1 | Active-video start of first visible line |
| ev_eof_line | input | 1 | Active-video start of end-of-frame line |
| ev_odd_to_even | input | 1 | Odd-to-even field transition |
| line_len | input | DW | Current line length |
| field_len | input | DW | Current field length |
| mode_sel | input | 2 | Fine exposure offset mode |
| work_fine | output | DW | Working fine exposure |
| work_coarse | output | DW | Working coarse exposure |
| work_clkdiv | output | DW | Working clock division |
| work_gain | output | DW | Working gain |
| work_pan | output | DW | Working pan offset |
| work_tilt | output | DW | Working tilt offset |
| work_vtim | output | DW | Working video timing |
| work_pan_cfg | output | 3 | Working readout configuration |
| pend_status | output | 7 | Pending bits indexed by category code |

## Verification
The assertions assume that `field_len` is at least 1 whenever coarse exposure loads. They also assume that event strobes last one cycle and come from a single timing source. The bench keeps `field_len` at realistic non-zero values. It raises each event for exactly one clock and drives every input on the falling edge. The write burst flag and the immediate options change only between scenarios, so each check matches a single known condition.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  localparam int NCAT = 7;
  typedef enum logic [2:0] {
    CAT_FINE   = 3'd0,
    CAT_COARSE = 3'd1,
    CAT_CLKDIV = 3'd2,
    CAT_GAIN   = 3'd3,
    CAT_PAN    = 3'd4,
    CAT_TILT   = 3'd5,
    CAT_VTIM   = 3'd6
  } cat_e;

  function automatic logic [7:0] fine_offset(input logic [1:0] mode);
    case (mode)
      2'd1:    fine_offset = 8'd86;
      2'd2:    fine_offset = 8'd23;
      default: fine_offset = 8'd51;
    endcase
  endfunction
endpackage

// File: rtl/shadow_slot.sv
module shadow_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          set,
  input  logic          imm_ld,
  input  logic          commit,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] shadow,
  output logic [DW-1:0] work,
  output logic          pend
);
  logic [DW-1:0] shadow_n, work_n;
  logic          pend_n;

  always_comb begin
    shadow_n = wr ? wdata : shadow;
    if (imm_ld)      work_n = wdata;
    else if (commit) work_n = load_val;
    else             work_n = work;
    pend_n = (pend & ~commit & ~imm_ld) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      work   <= '0;
      pend   <= 1'b0;
    end else begin
      shadow <= shadow_n;
      work   <= work_n;
      pend   <= pend_n;
    end
  end

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pend);
  // R2
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !set) |=> !pend);
  // R12
  work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !imm_ld) |=> $stable(work));
endmodule

// File: rtl/commit_sched.sv
module commit_sched
  import shreg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCAT-1:0] pend,
  input  logic            field_odd,
  input  logic            burst_active,
  input  logic            ev_dark_first,
  input  logic            ev_vis_first,
  input  logic            ev_eof_line,
  input  logic            ev_odd_to_even,
  output logic [NCAT-1:0] commit
);
  logic eof_odd, line_chg;

  always_comb begin
    eof_odd  = ev_eof_line & field_odd;
    line_chg = pend[CAT_VTIM];
    commit   = '0;
    commit[CAT_COARSE] = pend[CAT_COARSE] & ev_dark_first & field_odd;
    commit[CAT_TILT]   = pend[CAT_TILT] & ev_vis_first & field_odd;
    commit[CAT_GAIN]   = pend[CAT_GAIN] & eof_odd & ~burst_active;
    commit[CAT_PAN]    = pend[CAT_PAN] & eof_odd;
    commit[CAT_FINE]   = pend[CAT_FINE] &
                         ((eof_odd & ~line_chg) | (ev_odd_to_even & line_chg));
    commit[CAT_CLKDIV] = pend[CAT_CLKDIV] & ev_odd_to_even;
    commit[CAT_VTIM]   = pend[CAT_VTIM] & ev_odd_to_even;
  end

  // R8
  gain_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active |-> !commit[CAT_GAIN]);
  // R3
  coarse_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !field_odd |-> !commit[CAT_COARSE]);
endmodule

// File: rtl/exp_clip.sv
module exp_clip
  import shreg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] coarse_sh,
  input  logic [DW-1:0] fine_sh,
  input  logic [DW-1:0] line_len,
  input  logic [DW-1:0] field_len,
  input  logic [1:0]    mode_sel,
  output logic [DW-1:0] coarse_val,
  output logic [DW-1:0] fine_val
);
  logic [DW-1:0] off, fine_lim, coarse_lim;

  always_comb begin
    off        = DW'(fine_offset(mode_sel));
    fine_lim   = (line_len > off) ? (line_len - off) : '0;
    coarse_lim = (field_len != '0) ? (field_len - 1'b1) : '0;
    fine_val   = (fine_sh > fine_lim) ? fine_lim : fine_sh;
    coarse_val = (coarse_sh > coarse_lim) ? coarse_lim : coarse_sh;
  end
endmodule

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl
  import shreg_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_cat,
  input  logic [DW-1:0] wr_data,
  input  logic          burst_active,
  input  logic          imm_gain,
  input  logic          imm_clkdiv,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_val,
  input  logic          field_odd,
  input  logic          ev_dark_first,
  input  logic          ev_vis_first,
  input  logic          ev_eof_line,
  input  logic          ev_odd_to_even,
  input  logic [DW-1:0] line_len,
  input  logic [DW-1:0] field_len,
  input  logic [1:0]    mode_sel,
  output logic [DW-1:0] work_fine,
  output logic [DW-1:0] work_coarse,
  output logic [DW-1:0] work_clkdiv,
  output logic [DW-1:0] work_gain,
  output logic [DW-1:0] work_pan,
  output logic [DW-1:0] work_tilt,
  output logic [DW-1:0] work_vtim,
  output logic [2:0]    work_pan_cfg,
  output logic [NCAT-1:0] pend_status
);
  logic [DW-1:0]   sh_q   [NCAT];
  logic [DW-1:0]   work_q [NCAT];
  logic [DW-1:0]   ld_val [NCAT];
  logic [NCAT-1:0] pend_q, commit, wr_sel, imm_sel, set_sel;
  logic [DW-1:0]   fine_clip, coarse_clip;
  logic [2:0]      cfg_sh, cfg_sh_n, cfg_work_n;
  logic            cfg_chg;

  always_comb begin
    cfg_chg    = cfg_wr && (cfg_val != cfg_sh);
    cfg_sh_n   = cfg_wr ? cfg_val : cfg_sh;
    cfg_work_n = commit[CAT_PAN] ? cfg_sh : work_pan_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sh       <= '0;
      work_pan_cfg <= '0;
    end else begin
      cfg_sh       <= cfg_sh_n;
      work_pan_cfg <= cfg_work_n;
    end
  end

  exp_clip #(.DW(DW)) u_clip (
    .coarse_sh (sh_q[CAT_COARSE]),
    .fine_sh   (sh_q[CAT_FINE]),
    .line_len  (line_len),
    .field_len (field_len),
    .mode_sel  (mode_sel),
    .coarse_val(coarse_clip),
    .fine_val  (fine_clip)
  );

  commit_sched u_sched (
    .clk           (clk),
    .rst_n         (rst_n),
    .pend          (pend_q),
    .field_odd     (field_odd),
    .burst_active  (burst_active),
    .ev_dark_first (ev_dark_first),
    .ev_vis_first  (ev_vis_first),
    .ev_eof_line   (ev_eof_line),
    .ev_odd_to_even(ev_odd_to_even),
    .commit        (commit)
  );

  for (genvar i = 0; i < NCAT; i++) begin : g_slot
    localparam bit HAS_IMM = (i == CAT_GAIN) || (i == CAT_CLKDIV);
    localparam bit IS_PAN  = (i == CAT_PAN);

    assign wr_sel[i] = wr_en && (wr_cat == 3'(i));

    if (HAS_IMM) begin : g_imm
      assign imm_sel[i] = wr_sel[i] & ((i == CAT_GAIN) ? imm_gain : imm_clkdiv);
    end else begin : g_noimm
      assign imm_sel[i] = 1'b0;
    end

    if (IS_PAN) begin : g_pan
      assign set_sel[i] = wr_sel[i] | cfg_chg;
    end else begin : g_plain
      assign set_sel[i] = wr_sel[i] & ~imm_sel[i];
    end

    if (i == CAT_FINE) begin : g_lf
      assign ld_val[i] = fine_clip;
    end else if (i == CAT_COARSE) begin : g_lc
      assign ld_val[i] = coarse_clip;
    end else begin : g_ls
      assign ld_val[i] = sh_q[i];
    end

    shadow_slot #(.DW(DW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_sel[i]),
      .wdata   (wr_data),
      .set     (set_sel[i]),
      .imm_ld  (imm_sel[i]),
      .commit  (commit[i]),
      .load_val(ld_val[i]),
      .shadow  (sh_q[i]),
      .work    (work_q[i]),
      .pend    (pend_q[i])
    );
  end

  assign work_fine   = work_q[CAT_FINE];
  assign work_coarse = work_q[CAT_COARSE];
  assign work_clkdiv = work_q[CAT_CLKDIV];
  assign work_gain   = work_q[CAT_GAIN];
  assign work_pan    = work_q[CAT_PAN];
  assign work_tilt   = work_q[CAT_TILT];
  assign work_vtim   = work_q[CAT_VTIM];
  assign pend_status = pend_q;

  // R3
  coarse_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit[CAT_COARSE] |=> work_coarse <= $past(field_len) - 1'b1);
  // R10
  fine_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit[CAT_FINE] |=> work_fine <= $past(sh_q[CAT_FINE]));
  // R11
  pan_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit[CAT_PAN] |=> $stable(work_pan_cfg));
  // R8
  gain_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !imm_sel[CAT_GAIN]) |=> $stable(work_gain));
endmodule

// File: tb/shadow_commit_ctrl_bench.sv
module shadow_commit_ctrl_bench;
  localparam int DW = 16;
  logic clk = 1'b0, rst_n;
  logic wr_en, burst_active, imm_gain, imm_clkdiv, cfg_wr, field_odd;
  logic ev_dark_first, ev_vis_first, ev_eof_line, ev_odd_to_even;
  logic [2:0] wr_cat, cfg_val;
  logic [DW-1:0] wr_data, line_len, field_len;
  logic [1:0] mode_sel;
  logic [DW-1:0] work_fine, work_coarse, work_clkdiv, work_gain, work_pan, work_tilt, work_vtim;
  logic [2:0] work_pan_cfg;
  logic [6:0] pend_status;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  shadow_commit_ctrl #(.DW(DW)) u_shadow_commit_ctrl (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input int cat, input int val);
    wr_en = 1'b1; wr_cat = 3'(cat); wr_data = DW'(val);
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: ev_dark_first = 1'b1;
      1: ev_vis_first = 1'b1;
      2: ev_eof_line = 1'b1;
      default: ev_odd_to_even = 1'b1;
    endcase
    cyc();
    ev_dark_first = 0; ev_vis_first = 0; ev_eof_line = 0; ev_odd_to_even = 0;
  endtask

  task automatic t_reset();
    chk("R1 fine", work_fine, 0);     chk("R1 coarse", work_coarse, 0);
    chk("R1 gain", work_gain, 0);     chk("R1 vtim", work_vtim, 0);
    chk("R1 pend", pend_status, 0);
  endtask

  task automatic t_coarse();
    wr(1, 100);
    chk("R2 pend coarse", pend_status[1], 1);
    chk("R2 work unchanged", work_coarse, 0);
    field_odd = 0; pulse(0);
    chk("R3 even field", work_coarse, 0);
    field_odd = 1; pulse(0);
    chk("R3 odd load", work_coarse, 100);
    chk("R2 pend cleared", pend_status[1], 0);
    wr(1, 500); pulse(0);
    chk("R3 clip", work_coarse, 319);
  endtask

  task automatic t_tilt();
    wr(5, 33); pulse(2);
    chk("R4 wrong event", work_tilt, 0);
    pulse(1);
    chk("R4 load", work_tilt, 33);
  endtask

  task automatic t_gain_pan();
    wr(3, 7); wr(4, 21);
    burst_active = 1; pulse(2); burst_active = 0;
    chk("R8 gain skipped", work_gain, 0);
    chk("R8 still pending", pend_status[3], 1);
    chk("R5 pan load", work_pan, 21);
    pulse(2);
    chk("R5 gain load", work_gain, 7);
  endtask

  task automatic t_fine();
    wr(0, 200); pulse(2);
    chk("R6 eof load", work_fine, 200);
    wr(6, 9); wr(0, 300); pulse(2);
    chk("R6 held for line change", work_fine, 200);
    pulse(3);
    chk("R6 transition load", work_fine, 300);
    chk("R7 vtim", work_vtim, 9);
    wr(2, 3); pulse(2);
    chk("R7 clkdiv not at eof", work_clkdiv, 0);
    pulse(3);
    chk("R7 clkdiv", work_clkdiv, 3);
  endtask

  task automatic t_clip();
    mode_sel = 1; wr(0, 400); pulse(2);
    chk("R10 mode1", work_fine, 330);
    mode_sel = 2; line_len = 208; wr(0, 400); pulse(2);
    chk("R10 mode2", work_fine, 185);
    mode_sel = 0; line_len = 416; wr(0, 400); pulse(2);
    chk("R10 mode0", work_fine, 365);
  endtask

  task automatic t_imm();
    imm_gain = 1; wr(3, 55); imm_gain = 0;
    chk("R9 gain direct", work_gain, 55);
    chk("R9 gain not pending", pend_status[3], 0);
    imm_clkdiv = 1; wr(2, 12); imm_clkdiv = 0;
    chk("R9 clkdiv direct", work_clkdiv, 12);
  endtask

  task automatic t_pan_cfg();
    cfg_wr = 1; cfg_val = 0; cyc(); cfg_wr = 0;
    chk("R11 unchanged cfg", pend_status[4], 0);
    cfg_wr = 1; cfg_val = 3'b101; cyc(); cfg_wr = 0;
    chk("R11 changed cfg", pend_status[4], 1);
    chk("R11 cfg not yet", work_pan_cfg, 0);
    pulse(2);
    chk("R11 cfg applied", work_pan_cfg, 5);
    wr(4, 21);
    chk("R11 offset always", pend_status[4], 1);
    pulse(2);
  endtask

  task automatic t_collide();
    wr(5, 40);
    wr_en = 1; wr_cat = 5; wr_data = 41; ev_vis_first = 1;
    cyc();
    wr_en = 0; ev_vis_first = 0;
    chk("R12 old value", work_tilt, 40);
    chk("R12 still pending", pend_status[5], 1);
    pulse(1);
    chk("R12 new value", work_tilt, 41);
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_cat = 0; wr_data = 0; burst_active = 0;
    imm_gain = 0; imm_clkdiv = 0; cfg_wr = 0; cfg_val = 0; field_odd = 1;
    ev_dark_first = 0; ev_vis_first = 0; ev_eof_line = 0; ev_odd_to_even = 0;
    line_len = 416; field_len = 320; mode_sel = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_coarse();
    t_tilt();
    t_gain_pan();
    t_fine();
    t_clip();
    t_imm();
    t_pan_cfg();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule